// File: doc/BRIEF.md
# Sliding Window Image Generator

This block walks a row-major image held in a local pixel memory and hands every complete 3x3 neighbourhood to a downstream combinational kernel, one neighbourhood per iteration. It keeps three columns of pixels in shift registers. Each iteration pushes out the oldest column and pushes in one freshly read column. The memory is read only when a new column is required, and never more than once per clock. Border neighbourhoods are never formed, so an image of H rows and W columns yields (H-2)x(W-2) windows, in row-major order.

Image width, height and mode are sampled on a start pulse. In normal mode a band is three rows tall and bands step down one row at a time. In strip mode a band is four rows tall and bands step down two rows at a time. Each strip iteration then carries two vertically adjacent 3x3 windows for two kernel copies, and each image row is fetched twice instead of three times. The collector can hold off the generator with a stall input. A done pulse follows acceptance of the final window.

Top module: `swg_top`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `rd_en`, `win_valid` and `win_b_valid` are all low.
- R2: In normal mode, exactly (H-2)x(W-2) windows are presented in row-major order of their top-left corner (r,c). Window pixel (i,j), with i the row offset and j the column offset (0..2), sits at `win_a[(i*3+j)*8 +: 8]` and equals memory word (r+i)*W+(c+j).
- R3: Memory reads use address row*W+col, and data is returned on `rd_data` one cycle after `rd_en`. Each band reads every column of its rows exactly once, so a normal-mode run makes 3*W*(H-2) reads.
- R4: No read is issued while a window is being presented.
- R5: While `win_valid` is high and `stall` is high, the window stays valid and `win_a` and `win_b` do not change. A window is accepted on a clock edge where `win_valid` is high and `stall` is low.
- R6: In strip mode, bands start at rows 0, 2, 4, and so on. For a four-row band at row r, `win_a` holds rows r..r+2 and `win_b` holds rows r+1..r+3, both packed as in R2, and `win_b_valid` is high together with `win_valid`.
- R7: In strip mode, when only three rows remain below a band start, that band presents `win_a` only, with `win_b_valid` low. The total number of reads is W times the sum of the band heights.
- R8: `done` is high for exactly one cycle, in the cycle after the final window is accepted, and `busy` is low from the following cycle.
- R9: `start` is ignored while `busy` is high. Width, height and mode are used only as sampled on the accepted start pulse.
- R10: In normal mode `win_b_valid` is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan using the configuration inputs |
| cfg_width | input | DIM_W | Image width W in pixels (at least 3) |
| cfg_height | input | DIM_W | Image height H in rows (at least 3) |
| cfg_strip | input | 1 | 1 selects four-row bands with stride two |
| stall | input | 1 | Collector not ready; hold the current window |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 2*DIM_W | Memory word address |
| rd_data | input | PIX_W | Read data, valid one cycle after rd_en |
| win_valid | output | 1 | win_a holds a complete window |
| win_b_valid | output | 1 | win_b holds the lower window of a strip pair |
| win_a | output | 9*PIX_W | Upper (or only) 3x3 window |
| win_b | output | 9*PIX_W | Lower 3x3 window in strip mode |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse after the last window is accepted |

## Verification
The hardest case to reach is the final band of a strip scan on an image with an odd height. Only three rows remain there, so the lower window must be withheld and the read count changes, while the fourth row register still holds stale data from the previous band. The stimulus reaches it with odd-height strip images and a three-row strip image, combined with stall patterns that hold windows at band ends and on the very last window. A start pulse with different settings is also issued in the middle of a scan, and later windows must still follow the original geometry.

// File: rtl/swg_pkg.sv
package swg_pkg;

    localparam int WIN_DIM    = 3;
    localparam int STRIP_ROWS = 4;
    localparam int IDX_W      = $clog2(STRIP_ROWS);
    localparam int ROWCNT_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LAST,
        ST_OUT,
        ST_DONE
    } swg_state_e;

    // Height of a band given the rows remaining below its first row.
    function automatic logic [ROWCNT_W-1:0] band_rows(input logic strip, input int unsigned left);
        return (strip && left >= 32'd4) ? 3'd4 : 3'd3;
    endfunction

endpackage

// File: rtl/swg_ctrl.sv
module swg_ctrl
    import swg_pkg::*;
#(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 2 * DIM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic              cfg_strip,
    input  logic              stall,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              shift_en,
    output logic              win_valid,
    output logic              win_b_valid,
    output logic              busy,
    output logic              done
);

    localparam int EXT_W = DIM_W + 1;

    swg_state_e           state_q;
    logic [DIM_W-1:0]     width_q, height_q, row_q, col_q;
    logic                 strip_q;
    logic [IDX_W-1:0]     idx_q;
    logic [ROWCNT_W-1:0]  nrows_q;
    logic                 cap_en_q;
    logic [IDX_W-1:0]     cap_idx_q;

    logic [DIM_W-1:0]     row_nxt;
    logic                 band_last;
    logic                 col_last;
    logic                 idx_last;

    assign row_nxt   = row_q + (strip_q ? DIM_W'(2) : DIM_W'(1));
    assign band_last = (EXT_W'(row_nxt) + EXT_W'(3)) > EXT_W'(height_q);
    assign col_last  = (col_q == width_q - DIM_W'(1));
    assign idx_last  = ({1'b0, idx_q} == nrows_q - ROWCNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            width_q   <= '0;
            height_q  <= '0;
            strip_q   <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            idx_q     <= '0;
            nrows_q   <= ROWCNT_W'(3);
            cap_en_q  <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_en_q  <= rd_en;
            cap_idx_q <= idx_q;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        width_q  <= cfg_width;
                        height_q <= cfg_height;
                        strip_q  <= cfg_strip;
                        row_q    <= '0;
                        col_q    <= '0;
                        idx_q    <= '0;
                        nrows_q  <= band_rows(cfg_strip, 32'(cfg_height));
                        state_q  <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (idx_last) begin
                        idx_q   <= '0;
                        state_q <= ST_LAST;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_LAST: begin
                    if (col_q >= DIM_W'(2)) begin
                        state_q <= ST_OUT;
                    end else begin
                        col_q   <= col_q + DIM_W'(1);
                        state_q <= ST_READ;
                    end
                end
                ST_OUT: begin
                    if (!stall) begin
                        if (col_last) begin
                            if (band_last) begin
                                state_q <= ST_DONE;
                            end else begin
                                row_q   <= row_nxt;
                                col_q   <= '0;
                                nrows_q <= band_rows(strip_q, 32'(height_q - row_nxt));
                                state_q <= ST_READ;
                            end
                        end else begin
                            col_q   <= col_q + DIM_W'(1);
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_en       = (state_q == ST_READ);
    assign rd_addr     = (ADDR_W'(row_q) + ADDR_W'(idx_q)) * ADDR_W'(width_q) + ADDR_W'(col_q);
    assign cap_en      = cap_en_q;
    assign cap_idx     = cap_idx_q;
    assign shift_en    = (state_q == ST_LAST);
    assign win_valid   = (state_q == ST_OUT);
    assign win_b_valid = (state_q == ST_OUT) && (nrows_q == ROWCNT_W'(4));
    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);

endmodule

// File: rtl/swg_window.sv
module swg_window
    import swg_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int WIN_W = WIN_DIM * WIN_DIM * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic              shift_en,
    input  logic [PIX_W-1:0]  rd_data,
    output logic [WIN_W-1:0]  win_a,
    output logic [WIN_W-1:0]  win_b
);

    logic [PIX_W-1:0] colbuf_q [STRIP_ROWS];
    logic [PIX_W-1:0] fresh    [STRIP_ROWS];
    logic [PIX_W-1:0] tap_q    [WIN_DIM][STRIP_ROWS];

    // Incoming column: buffered rows plus the pixel arriving this cycle.
    always_comb begin
        for (int r = 0; r < STRIP_ROWS; r++) begin
            fresh[r] = (cap_en && (cap_idx == IDX_W'(r))) ? rd_data : colbuf_q[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < STRIP_ROWS; r++) begin
                colbuf_q[r] <= '0;
                for (int c = 0; c < WIN_DIM; c++) tap_q[c][r] <= '0;
            end
        end else begin
            for (int r = 0; r < STRIP_ROWS; r++) begin
                if (cap_en) colbuf_q[r] <= fresh[r];
                if (shift_en) begin
                    for (int c = 0; c < WIN_DIM - 1; c++) tap_q[c][r] <= tap_q[c+1][r];
                    tap_q[WIN_DIM-1][r] <= fresh[r];
                end
            end
        end
    end

    for (genvar r = 0; r < WIN_DIM; r++) begin : g_row
        for (genvar c = 0; c < WIN_DIM; c++) begin : g_col
            assign win_a[(r*WIN_DIM+c)*PIX_W +: PIX_W] = tap_q[c][r];
            assign win_b[(r*WIN_DIM+c)*PIX_W +: PIX_W] = tap_q[c][r+1];
        end
    end

endmodule

// File: rtl/swg_top.sv
module swg_top
    import swg_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DIM_W = 8,
    localparam int ADDR_W = 2 * DIM_W,
    localparam int WIN_W  = WIN_DIM * WIN_DIM * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic              cfg_strip,
    input  logic              stall,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [PIX_W-1:0]  rd_data,
    output logic              win_valid,
    output logic              win_b_valid,
    output logic [WIN_W-1:0]  win_a,
    output logic [WIN_W-1:0]  win_b,
    output logic              busy,
    output logic              done
);

    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;
    logic             shift_en;

    swg_ctrl #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .cfg_strip  (cfg_strip),
        .stall      (stall),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .cap_en     (cap_en),
        .cap_idx    (cap_idx),
        .shift_en   (shift_en),
        .win_valid  (win_valid),
        .win_b_valid(win_b_valid),
        .busy       (busy),
        .done       (done)
    );

    swg_window #(.PIX_W(PIX_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .shift_en(shift_en),
        .rd_data (rd_data),
        .win_a   (win_a),
        .win_b   (win_b)
    );

endmodule

// File: rtl/swg_checker.sv
module swg_checker #(
    parameter int PIX_W = 8,
    parameter int DIM_W = 8,
    localparam int ADDR_W = 2 * DIM_W,
    localparam int WIN_W  = 9 * PIX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [DIM_W-1:0]  cfg_width,
    input logic [DIM_W-1:0]  cfg_height,
    input logic              cfg_strip,
    input logic              stall,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              win_valid,
    input logic              win_b_valid,
    input logic [WIN_W-1:0]  win_a,
    input logic [WIN_W-1:0]  win_b,
    input logic              busy,
    input logic              done
);

    logic              chk_strip;
    logic [ADDR_W-1:0] chk_area;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_strip <= 1'b0;
            chk_area  <= '0;
        end else if (start && !busy) begin
            chk_strip <= cfg_strip;
            chk_area  <= ADDR_W'(cfg_width) * ADDR_W'(cfg_height);
        end
    end

    AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (rst) !busy |-> (!rd_en && !win_valid && !done)); // R1
    AST_ADDR_RANGE:   assert property (@(posedge clk) disable iff (rst) rd_en |-> (rd_addr < chk_area)); // R3
    AST_NO_FETCH_HELD: assert property (@(posedge clk) disable iff (rst) win_valid |-> !rd_en); // R4
    AST_HOLD_VALID:   assert property (@(posedge clk) disable iff (rst) (win_valid && stall) |=> win_valid); // R5
    AST_HOLD_DATA:    assert property (@(posedge clk) disable iff (rst) (win_valid && stall) |=> ($stable(win_a) && $stable(win_b))); // R5
    AST_B_NEEDS_A:    assert property (@(posedge clk) disable iff (rst) win_b_valid |-> win_valid); // R6
    AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst) done |=> !busy); // R8
    AST_B_NOT_NORMAL: assert property (@(posedge clk) disable iff (rst) win_b_valid |-> chk_strip); // R10

endmodule

bind swg_top swg_checker #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .cfg_strip  (cfg_strip),
    .stall      (stall),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .win_valid  (win_valid),
    .win_b_valid(win_b_valid),
    .win_a      (win_a),
    .win_b      (win_b),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_swg_top.sv
module sim_swg_top;

    localparam int PIX_W = 8;
    localparam int DIM_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [DIM_W-1:0]  cfg_width = '0;
    logic [DIM_W-1:0]  cfg_height = '0;
    logic              cfg_strip = 1'b0;
    logic              stall = 1'b0;
    logic              rd_en;
    logic [2*DIM_W-1:0] rd_addr;
    logic [PIX_W-1:0]  rd_data = '0;
    logic              win_valid, win_b_valid, busy, done;
    logic [71:0]       win_a, win_b;

    int n_chk = 0, n_err = 0, cyc = 0;
    int seed = 0, smode = 0, rd_cnt = 0, done_cnt = 0, exp_reads = 0;
    bit run_on = 0, strip_run = 0, wd_hit = 0, acc_prev = 0, hold_prev = 0;
    logic [71:0] held_a, held_b;
    logic [71:0] exp_a[$], exp_b[$];
    bit          exp_bv[$];

    always #10 clk = ~clk;

    swg_top #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_strip(cfg_strip), .stall(stall), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .win_valid(win_valid), .win_b_valid(win_b_valid), .win_a(win_a), .win_b(win_b),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] pix(input int a);
        return 8'(a * 29 + seed * 13 + (a >> 3));
    endfunction

    function automatic logic [71:0] win_at(input int r, input int c, input int w);
        logic [71:0] v;
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                v[(i*3+j)*8 +: 8] = pix((r + i) * w + c + j);
        return v;
    endfunction

    // Memory model: one-cycle synchronous read.
    always @(posedge clk) if (rd_en) rd_data <= pix(int'(rd_addr));

    task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic build_expect(input int w, input int h, input bit s);
        exp_a.delete(); exp_b.delete(); exp_bv.delete();
        exp_reads = 0;
        if (!s) begin
            for (int r = 0; r + 3 <= h; r++) begin
                exp_reads += 3 * w;
                for (int c = 0; c + 3 <= w; c++) begin
                    exp_a.push_back(win_at(r, c, w)); exp_b.push_back('0); exp_bv.push_back(1'b0);
                end
            end
        end else begin
            for (int r = 0; r + 3 <= h; r += 2) begin
                bit four = (h - r) >= 4;
                exp_reads += (four ? 4 : 3) * w;
                for (int c = 0; c + 3 <= w; c++) begin
                    exp_a.push_back(win_at(r, c, w));
                    exp_b.push_back(four ? win_at(r + 1, c, w) : 72'd0);
                    exp_bv.push_back(four);
                end
            end
        end
    endtask

    // Cycle-by-cycle comparison against the queued reference windows.
    always @(negedge clk) begin
        bit acc;
        cyc++;
        case (smode)
            0:       stall = 1'b0;
            1:       stall = (cyc % 3 == 0);
            default: stall = (cyc % 5 != 0);
        endcase
        acc = 0;
        if (run_on) begin
            if (rd_en) rd_cnt++;
            if (hold_prev) begin
                check(win_valid && win_a == held_a && win_b == held_b, "R5", win_a, held_a);
            end
            if (win_valid) begin
                if (exp_a.size() == 0) begin
                    check(1'b0, strip_run ? "R6" : "R2", win_a, 72'd0);
                end else begin
                    check(win_a == exp_a[0], strip_run ? "R6" : "R2", win_a, exp_a[0]);
                    check(win_b_valid == exp_bv[0], strip_run ? "R7" : "R10", 72'(win_b_valid), 72'(exp_bv[0]));
                    if (exp_bv[0]) check(win_b == exp_b[0], "R6", win_b, exp_b[0]);
                    if (!stall) begin
                        void'(exp_a.pop_front()); void'(exp_b.pop_front()); void'(exp_bv.pop_front());
                        acc = 1;
                    end
                end
            end
            if (done) begin
                done_cnt++;
                check(acc_prev && exp_a.size() == 0, "R8", 72'(acc_prev), 72'd1);
            end
            hold_prev = win_valid && stall;
            held_a = win_a;
            held_b = win_b;
        end
        acc_prev = acc;
        if (cyc > 100000 && !wd_hit) begin
            wd_hit = 1;
            n_chk++; n_err++;
            $display("FAIL R8 watchdog actual=no_done expected=done");
        end
    end

    task automatic run_case(input int w, input int h, input bit s, input int sd, input int sm, input bit poke);
        seed = sd; smode = sm; strip_run = s;
        build_expect(w, h, s);
        rd_cnt = 0; done_cnt = 0;
        cfg_width = DIM_W'(w); cfg_height = DIM_W'(h); cfg_strip = s;
        @(negedge clk); start = 1'b1; run_on = 1;
        @(negedge clk); start = 1'b0;
        // R9: settings changed after the accepted start must have no effect
        cfg_width = DIM_W'(3); cfg_height = DIM_W'(3); cfg_strip = ~s;
        if (poke) begin
            repeat (7) @(negedge clk);
            start = 1'b1;                       // R9: start while busy is ignored
            @(negedge clk); start = 1'b0;
        end
        while (done_cnt == 0 && !wd_hit) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_a.size() == 0, s ? "R6" : "R2", 72'(exp_a.size()), 72'd0);
        check(rd_cnt == exp_reads, s ? "R7" : "R3", 72'(rd_cnt), 72'(exp_reads));
        check(done_cnt == 1, "R8", 72'(done_cnt), 72'd1);
        check(!busy, "R8", 72'(busy), 72'd0);
        check(!win_valid && !rd_en, "R9", {70'd0, win_valid, rd_en}, 72'd0);
        run_on = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rd_en && !win_valid && !win_b_valid, "R1",
              {67'd0, busy, done, rd_en, win_valid, win_b_valid}, 72'd0);
        run_case(5, 5, 1'b0, 1, 0, 1'b0);
        run_case(3, 3, 1'b0, 2, 1, 1'b0);
        run_case(6, 6, 1'b1, 3, 2, 1'b0);
        run_case(7, 5, 1'b1, 4, 1, 1'b1);
        run_case(4, 3, 1'b1, 5, 2, 1'b0);
        run_case(8, 4, 1'b0, 6, 2, 1'b1);
        run_case(9, 7, 1'b1, 7, 0, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule